// File: doc/BRIEF.md
# Processor Interrupt Delivery Controller

This block stands between a processor core and the sources that interrupt it. Three kinds of request arrive from outside: a reset request, a non-maskable interrupt (NMI) request, and a maskable interrupt level that comes with a valid strobe. Each request is held in its own pending register. The core marks every instruction boundary with a strobe, and the block decides what to deliver only at those boundaries. It raises a single-cycle exception pulse toward the core and keeps the hardware-interrupt-pending field of the core's cause register up to date.

A new request arms one evaluation at a later boundary. That boundary serves one request by fixed priority: reset, then NMI, then the maskable level. Reset and NMI share one exception output. The maskable level is delivered only when the status interrupt enable is set and the level overlaps the status interrupt mask. A level that cannot be delivered stays pending and is tried again at every following boundary. A level value of zero withdraws the interrupt and clears the cause field.

Top module: `irq_deliver_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the block clears all pending requests and the evaluation arming, and sets `cause_ip_o` to 0. After reset, a boundary raises no exception pulse until a request has arrived.
- R2: Requests are evaluated only when `boundary_i` is high. Exception pulses are high only in a cycle where `boundary_i` is high, and `cause_ip_o` changes only on the clock edge that ends such a cycle.
- R3: Each serviced boundary serves exactly one request. A pending reset comes first, then a pending NMI, then the pending level. A serviced reset or NMI raises `nmi_rst_exc_o` and clears only its own pending flag.
- R4: Once a reset or NMI has been serviced, evaluation is disarmed. Requests still pending wait until a new request arrives on any input. The next boundary after that serves the highest-priority pending request.
- R5: When a pending nonzero level is evaluated, `cause_ip_o` takes bits [IP_W-1:0] of the level value, starting the cycle after the boundary. The value is held in those bit positions.
- R6: A pending nonzero level is delivered when `sr_ie_i` is 1 and the bitwise AND of its low IP_W bits with `sr_im_i` is nonzero. Delivery raises `int_exc_o` for that boundary cycle and clears the pending level.
- R7: A nonzero level that cannot be delivered stays pending and armed. It is evaluated again at every later boundary, with `cause_ip_o` reloaded each time, until it is delivered or replaced.
- R8: A level strobe with value 0 records an end-of-interrupt marker. When the marker is serviced, `cause_ip_o` becomes 0 and no pulse is raised. The level path then goes idle, so later boundaries raise no interrupt pulse.
- R9: A newer level strobe replaces any older pending level value or marker that has not yet been serviced.
- R10: A request that arrives in the same cycle as `boundary_i` is not evaluated at that boundary, and no other pending request is serviced there either. It is evaluated at the next boundary.
- R11: A nonzero level whose low IP_W bits are all zero leaves `cause_ip_o` at 0 and is never delivered. It stays pending until it is replaced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rst_req_i | input | 1 | Reset request pulse |
| nmi_req_i | input | 1 | Non-maskable interrupt request pulse |
| lvl_valid_i | input | 1 | Strobe marking `lvl_value_i` as a new level |
| lvl_value_i | input | LVL_W | Maskable interrupt level; 0 means withdrawn |
| boundary_i | input | 1 | Instruction-boundary strobe from the core |
| sr_ie_i | input | 1 | Status current-interrupt-enable bit |
| sr_im_i | input | IP_W | Status interrupt mask |
| cause_ip_o | output | IP_W | Hardware-interrupt-pending field of the cause register |
| nmi_rst_exc_o | output | 1 | One-cycle reset/NMI exception request |
| int_exc_o | output | 1 | One-cycle maskable-interrupt exception request |

## Verification
The bound checker watches several properties on every cycle:
- exception pulses appear only with a boundary;
- the cause field changes only after a boundary;
- the two pulses are never high together;
- no pulse comes in a cycle that also carries a new request;
- an interrupt pulse needs the enable bit and a loaded cause field that overlaps the mask.

Other behaviour needs history that only the directed scenarios build up. This covers the priority order and the disarming after a reset or NMI is serviced. It also covers repeated retries of a blocked level, replacement of one level by another, the end-of-interrupt marker, and a level whose only set bits lie above the cause field.

// File: rtl/irqd_pkg.sv
package irqd_pkg;

    // Level path occupancy
    typedef enum logic [1:0] {
        LVL_IDLE = 2'd0,
        LVL_REQ  = 2'd1,
        LVL_EOI  = 2'd2
    } lvl_state_e;

    // What a boundary decided to do
    typedef enum logic [2:0] {
        SVC_NONE     = 3'd0,
        SVC_RST      = 3'd1,
        SVC_NMI      = 3'd2,
        SVC_LVL_TAKE = 3'd3,
        SVC_LVL_HOLD = 3'd4,
        SVC_LVL_EOI  = 3'd5
    } svc_kind_e;

    typedef struct packed {
        logic       rst;
        logic       nmi;
        lvl_state_e lvl;
    } pend_t;

    function automatic logic svc_touches_cause(svc_kind_e k);
        return (k == SVC_LVL_TAKE) || (k == SVC_LVL_HOLD) || (k == SVC_LVL_EOI);
    endfunction

    function automatic logic svc_keeps_armed(svc_kind_e k);
        return (k == SVC_LVL_HOLD);
    endfunction

    function automatic logic svc_is_nmi_rst(svc_kind_e k);
        return (k == SVC_RST) || (k == SVC_NMI);
    endfunction

endpackage

// File: rtl/irqd_req_latch.sv
module irqd_req_latch
    import irqd_pkg::*;
#(
    parameter int unsigned IP_W  = 6,
    parameter int unsigned LVL_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            rst_req_i,
    input  logic            nmi_req_i,
    input  logic            lvl_valid_i,
    input  logic [LVL_W-1:0] lvl_value_i,
    input  logic            eval_i,
    input  svc_kind_e       svc_i,
    output pend_t           pend_o,
    output logic [IP_W-1:0] lvl_ip_o,
    output logic            armed_o,
    output logic            req_any_o
);

    logic            lvl_nonzero;
    logic [IP_W-1:0] lvl_ip_in;

    assign lvl_nonzero = |lvl_value_i;

    generate
        if (LVL_W >= IP_W) begin : g_slice
            assign lvl_ip_in = lvl_value_i[IP_W-1:0];
        end else begin : g_extend
            assign lvl_ip_in = {{(IP_W-LVL_W){1'b0}}, lvl_value_i};
        end
    endgenerate

    assign req_any_o = rst_req_i | nmi_req_i | lvl_valid_i;

    pend_t           pend_q;
    logic [IP_W-1:0] lvl_ip_q;
    logic            armed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q   <= '{rst: 1'b0, nmi: 1'b0, lvl: LVL_IDLE};
            lvl_ip_q <= '0;
            armed_q  <= 1'b0;
        end else begin
            // retire whatever the boundary served
            case (svc_i)
                SVC_RST:      pend_q.rst <= 1'b0;
                SVC_NMI:      pend_q.nmi <= 1'b0;
                SVC_LVL_TAKE: pend_q.lvl <= LVL_IDLE;
                SVC_LVL_EOI:  pend_q.lvl <= LVL_IDLE;
                default: ;
            endcase
            // capture new requests
            if (rst_req_i) pend_q.rst <= 1'b1;
            if (nmi_req_i) pend_q.nmi <= 1'b1;
            if (lvl_valid_i) begin
                pend_q.lvl <= lvl_nonzero ? LVL_REQ : LVL_EOI;
                lvl_ip_q   <= lvl_ip_in;
            end
            // arming of the next evaluation
            if (req_any_o)
                armed_q <= 1'b1;
            else if (eval_i && !svc_keeps_armed(svc_i))
                armed_q <= 1'b0;
        end
    end

    assign pend_o   = pend_q;
    assign lvl_ip_o = lvl_ip_q;
    assign armed_o  = armed_q;

endmodule

// File: rtl/irqd_arbiter.sv
module irqd_arbiter
    import irqd_pkg::*;
#(
    parameter int unsigned IP_W = 6
) (
    input  logic            boundary_i,
    input  logic            armed_i,
    input  logic            req_any_i,
    input  pend_t           pend_i,
    input  logic [IP_W-1:0] lvl_ip_i,
    input  logic            sr_ie_i,
    input  logic [IP_W-1:0] sr_im_i,
    output logic            eval_o,
    output svc_kind_e       svc_o,
    output logic [IP_W-1:0] ip_next_o
);

    logic deliverable;

    // a fresh request restarts the wait for a boundary
    assign eval_o      = boundary_i & armed_i & ~req_any_i;
    assign deliverable = sr_ie_i & (|(lvl_ip_i & sr_im_i));

    always_comb begin
        svc_o     = SVC_NONE;
        ip_next_o = '0;
        if (eval_o) begin
            if (pend_i.rst) begin
                svc_o = SVC_RST;
            end else if (pend_i.nmi) begin
                svc_o = SVC_NMI;
            end else if (pend_i.lvl == LVL_REQ) begin
                ip_next_o = lvl_ip_i;
                svc_o     = deliverable ? SVC_LVL_TAKE : SVC_LVL_HOLD;
            end else if (pend_i.lvl == LVL_EOI) begin
                svc_o = SVC_LVL_EOI;
            end
        end
    end

endmodule

// File: rtl/irqd_cause_reg.sv
module irqd_cause_reg
    import irqd_pkg::*;
#(
    parameter int unsigned IP_W = 6
) (
    input  logic            clk,
    input  logic            rst,
    input  svc_kind_e       svc_i,
    input  logic [IP_W-1:0] ip_next_i,
    output logic [IP_W-1:0] cause_ip_o
);

    logic [IP_W-1:0] ip_q;

    always_ff @(posedge clk) begin
        if (rst)
            ip_q <= '0;
        else if (svc_touches_cause(svc_i))
            ip_q <= ip_next_i;
    end

    assign cause_ip_o = ip_q;

endmodule

// File: rtl/irq_deliver_ctrl.sv
module irq_deliver_ctrl
    import irqd_pkg::*;
#(
    parameter int unsigned IP_W  = 6,
    parameter int unsigned LVL_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rst_req_i,
    input  logic             nmi_req_i,
    input  logic             lvl_valid_i,
    input  logic [LVL_W-1:0] lvl_value_i,
    input  logic             boundary_i,
    input  logic             sr_ie_i,
    input  logic [IP_W-1:0]  sr_im_i,
    output logic [IP_W-1:0]  cause_ip_o,
    output logic             nmi_rst_exc_o,
    output logic             int_exc_o
);

    pend_t           pend;
    logic [IP_W-1:0] lvl_ip;
    logic            armed;
    logic            req_any;
    logic            eval;
    svc_kind_e       svc;
    logic [IP_W-1:0] ip_next;

    irqd_req_latch #(.IP_W(IP_W), .LVL_W(LVL_W)) u_latch (
        .clk         (clk),
        .rst         (rst),
        .rst_req_i   (rst_req_i),
        .nmi_req_i   (nmi_req_i),
        .lvl_valid_i (lvl_valid_i),
        .lvl_value_i (lvl_value_i),
        .eval_i      (eval),
        .svc_i       (svc),
        .pend_o      (pend),
        .lvl_ip_o    (lvl_ip),
        .armed_o     (armed),
        .req_any_o   (req_any)
    );

    irqd_arbiter #(.IP_W(IP_W)) u_arb (
        .boundary_i (boundary_i),
        .armed_i    (armed),
        .req_any_i  (req_any),
        .pend_i     (pend),
        .lvl_ip_i   (lvl_ip),
        .sr_ie_i    (sr_ie_i),
        .sr_im_i    (sr_im_i),
        .eval_o     (eval),
        .svc_o      (svc),
        .ip_next_o  (ip_next)
    );

    irqd_cause_reg #(.IP_W(IP_W)) u_cause (
        .clk        (clk),
        .rst        (rst),
        .svc_i      (svc),
        .ip_next_i  (ip_next),
        .cause_ip_o (cause_ip_o)
    );

    assign nmi_rst_exc_o = svc_is_nmi_rst(svc);
    assign int_exc_o     = (svc == SVC_LVL_TAKE);

endmodule

// File: rtl/irqd_checker.sv
module irqd_checker #(
    parameter int unsigned IP_W = 6
) (
    input logic            clk,
    input logic            rst,
    input logic            rst_req_i,
    input logic            nmi_req_i,
    input logic            lvl_valid_i,
    input logic            boundary_i,
    input logic            sr_ie_i,
    input logic [IP_W-1:0] sr_im_i,
    input logic [IP_W-1:0] cause_ip_o,
    input logic            nmi_rst_exc_o,
    input logic            int_exc_o
);

    // R1
    a_r1_reset_clears_cause: assert property (@(posedge clk)
        rst |=> (cause_ip_o == '0));

    // R2
    a_r2_pulse_needs_boundary: assert property (@(posedge clk) disable iff (rst)
        (nmi_rst_exc_o || int_exc_o) |-> boundary_i);

    // R2
    a_r2_cause_moves_after_boundary: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && (cause_ip_o != $past(cause_ip_o))) |-> $past(boundary_i));

    // R3
    a_r3_one_service: assert property (@(posedge clk) disable iff (rst)
        $onehot0({nmi_rst_exc_o, int_exc_o}));

    // R10
    a_r10_no_pulse_with_request: assert property (@(posedge clk) disable iff (rst)
        (rst_req_i || nmi_req_i || lvl_valid_i) |-> !(nmi_rst_exc_o || int_exc_o));

    // R6
    a_r6_needs_enable: assert property (@(posedge clk) disable iff (rst)
        int_exc_o |-> sr_ie_i);

    // R6
    a_r6_overlaps_mask: assert property (@(posedge clk) disable iff (rst)
        int_exc_o |=> ((cause_ip_o & $past(sr_im_i)) != '0));

endmodule

bind irq_deliver_ctrl irqd_checker #(.IP_W(IP_W)) u_irqd_chk (
    .clk           (clk),
    .rst           (rst),
    .rst_req_i     (rst_req_i),
    .nmi_req_i     (nmi_req_i),
    .lvl_valid_i   (lvl_valid_i),
    .boundary_i    (boundary_i),
    .sr_ie_i       (sr_ie_i),
    .sr_im_i       (sr_im_i),
    .cause_ip_o    (cause_ip_o),
    .nmi_rst_exc_o (nmi_rst_exc_o),
    .int_exc_o     (int_exc_o)
);

// File: tb/irq_deliver_ctrl_test.sv
`timescale 1ns/1ps
module irq_deliver_ctrl_test;

    localparam int IP_W  = 6;
    localparam int LVL_W = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             rst_req_i = 1'b0;
    logic             nmi_req_i = 1'b0;
    logic             lvl_valid_i = 1'b0;
    logic [LVL_W-1:0] lvl_value_i = '0;
    logic             boundary_i = 1'b0;
    logic             sr_ie_i = 1'b0;
    logic [IP_W-1:0]  sr_im_i = '0;
    logic [IP_W-1:0]  cause_ip_o;
    logic             nmi_rst_exc_o;
    logic             int_exc_o;

    int n_checks = 0;
    int n_fail   = 0;
    logic got_nr, got_int;

    always #5 clk = ~clk;

    irq_deliver_ctrl #(.IP_W(IP_W), .LVL_W(LVL_W)) uut (
        .clk           (clk),
        .rst           (rst),
        .rst_req_i     (rst_req_i),
        .nmi_req_i     (nmi_req_i),
        .lvl_valid_i   (lvl_valid_i),
        .lvl_value_i   (lvl_value_i),
        .boundary_i    (boundary_i),
        .sr_ie_i       (sr_ie_i),
        .sr_im_i       (sr_im_i),
        .cause_ip_o    (cause_ip_o),
        .nmi_rst_exc_o (nmi_rst_exc_o),
        .int_exc_o     (int_exc_o)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // One clock cycle: drive strobes right after an edge, sample the
    // combinational pulses mid-cycle, then release after the next edge.
    task automatic cyc(input logic r, input logic n, input logic lv,
                       input logic [LVL_W-1:0] val, input logic b);
        rst_req_i   = r;
        nmi_req_i   = n;
        lvl_valid_i = lv;
        lvl_value_i = val;
        boundary_i  = b;
        #2;
        got_nr  = nmi_rst_exc_o;
        got_int = int_exc_o;
        @(posedge clk);
        #1;
        rst_req_i   = 1'b0;
        nmi_req_i   = 1'b0;
        lvl_valid_i = 1'b0;
        boundary_i  = 1'b0;
    endtask

    task automatic bnd(input string req, input int exp_nr, input int exp_int, input int exp_ip);
        cyc(1'b0, 1'b0, 1'b0, '0, 1'b1);
        check({req, " nmi_rst pulse"}, int'(got_nr), exp_nr);
        check({req, " int pulse"}, int'(got_int), exp_int);
        check({req, " cause"}, int'(cause_ip_o), exp_ip);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        @(posedge clk); #1;
        @(posedge clk); #1;
        rst = 1'b0;
        check("R1 cause after reset", int'(cause_ip_o), 0);
        sr_ie_i = 1'b1; sr_im_i = '1;
        bnd("R1 boundary with nothing armed", 0, 0, 0);
    endtask

    task automatic t_no_boundary;
        cyc(1'b0, 1'b1, 1'b0, '0, 1'b0);
        check("R2 request without boundary", int'(got_nr | got_int), 0);
        for (int i = 0; i < 3; i++) begin
            cyc(1'b0, 1'b0, 1'b0, '0, 1'b0);
            check("R2 idle cycles", int'(got_nr | got_int), 0);
        end
        bnd("R3 nmi served", 1, 0, 0);
        bnd("R4 nothing left", 0, 0, 0);
    endtask

    task automatic t_priority;
        sr_ie_i = 1'b1; sr_im_i = '1;
        cyc(1'b1, 1'b1, 1'b1, 8'h03, 1'b0);
        bnd("R3 reset first", 1, 0, 0);
        bnd("R4 disarmed after reset", 0, 0, 0);
        cyc(1'b0, 1'b0, 1'b1, 8'h05, 1'b0);   // R9 replaces level 3
        bnd("R4 rearmed serves nmi", 1, 0, 0);
        bnd("R4 disarmed after nmi", 0, 0, 0);
        cyc(1'b0, 1'b0, 1'b1, 8'h05, 1'b0);
        bnd("R9 newer level delivered", 0, 1, 5);
        bnd("R6 level cleared after delivery", 0, 0, 5);
    endtask

    task automatic t_hold;
        sr_ie_i = 1'b0; sr_im_i = '1;
        cyc(1'b0, 1'b0, 1'b1, 8'h0A, 1'b0);
        bnd("R5 cause loaded while disabled", 0, 0, 8'h0A);
        bnd("R7 still held", 0, 0, 8'h0A);
        sr_ie_i = 1'b1; sr_im_i = 6'h01;
        bnd("R6 mask does not overlap", 0, 0, 8'h0A);
        sr_im_i = 6'h02;
        bnd("R7 delivered on later boundary", 0, 1, 8'h0A);
        bnd("R7 no repeat", 0, 0, 8'h0A);
    endtask

    task automatic t_eoi;
        sr_ie_i = 1'b0; sr_im_i = '1;
        cyc(1'b0, 1'b0, 1'b1, 8'h3F, 1'b0);
        bnd("R5 all bits", 0, 0, 8'h3F);
        cyc(1'b0, 1'b0, 1'b1, 8'h00, 1'b0);
        bnd("R8 marker clears cause", 0, 0, 0);
        sr_ie_i = 1'b1;
        bnd("R8 idle after marker", 0, 0, 0);
    endtask

    task automatic t_same_cycle;
        sr_ie_i = 1'b1; sr_im_i = '1;
        cyc(1'b0, 1'b0, 1'b1, 8'h04, 1'b1);
        check("R10 not served in arrival cycle", int'(got_nr | got_int), 0);
        check("R10 cause untouched", int'(cause_ip_o), 0);
        bnd("R10 served next boundary", 0, 1, 4);
    endtask

    task automatic t_high_bits;
        sr_ie_i = 1'b1; sr_im_i = '1;
        cyc(1'b0, 1'b0, 1'b1, 8'hC0, 1'b0);
        bnd("R11 high-only level", 0, 0, 0);
        bnd("R11 still never delivered", 0, 0, 0);
        cyc(1'b0, 1'b0, 1'b1, 8'h41, 1'b0);
        bnd("R11 replaced by deliverable level", 0, 1, 1);
    endtask

    initial begin
        #200000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        @(posedge clk); #1;
        t_reset();
        t_no_boundary();
        t_priority();
        t_hold();
        t_eoi();
        t_same_cycle();
        t_high_bits();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule